// File: doc/BRIEF.md
# Multi-Channel Interrupt Aggregator

The block merges the interrupt requests of sixteen serial channels into a single device interrupt line. Each channel request input is captured every clock into a read-only status vector. A per-channel block register decides which channels may reach the output: a one in a channel's bit holds that channel back, and a zero lets it through. A separate global enable gates the combined result.

Software reads and writes the registers through a simple word-addressed port. It can see the raw status, the block register, the effective pending vector (status with the blocked channels removed) and the control word that holds the global enable. After reset every channel is blocked and the global enable is off. Software opens channels one by one from that state. The output line is registered, so a read-modify-write of the block register can never leave a short pulse on it.

Top module: `chan_irq_combiner`

## Requirements
- R1: Status bit n (word address 0) equals the level of channel request input n, captured at each clock edge. A write to address 0 has no effect on the status.
- R2: In the block register (word address 1) bit n set to 1 holds channel n back, and a 0 lets it through. Bits 16 to 31 read 0.
- R3: Word address 2 reads the effective pending vector, which is status AND NOT block, in bits 0 to 15. A write to it has no effect.
- R4: The global enable is bit 20 of the control word at address 3. Every other control bit reads 0, whatever was written.
- R5: The interrupt output is 1 exactly when, one clock earlier, the global enable was set and the effective pending vector was non-zero. A register change reaches the output one clock after the register updates.
- R6: After reset the block register reads 0x0000FFFF, the control word reads 0, the pending vector reads 0 and the interrupt output is 0.
- R7: Writing all ones to the block register forces the interrupt output to 0 from the following clock, whatever the requests are.
- R8: Rewriting the block register with its current value leaves the interrupt output unchanged in every cycle.
- R9: Read data appears on the read-data output in the clock after the read strobe and holds until the next read. Any address above 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_req | input | 16 | Interrupt request level of each channel |
| reg_addr | input | 4 | Word address for reads and writes |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd_en | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| dev_irq | output | 1 | Combined device interrupt, registered |

## Verification
The main function is driven by a table of request, block and enable combinations. The table covers a single lowest channel and a single highest channel, two complementary checkerboard patterns, a request set that is fully covered by the block register, all channels open, and no requests at all. These cases separate a correct AND-NOT from a plain AND or a missing inversion, catch a wrong bit order at the channel ends, and show that the enable gates the line. Directed cases then check the reset values, the one-cycle latency of the output, that writes to read-only and unused bits are ignored, and that the output stays quiet both when the block register is rewritten with its current value and when it is written with all ones.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned AGG_DATA_W  = 32;
  localparam int unsigned ADDR_STATUS = 0;
  localparam int unsigned ADDR_BLOCK  = 1;
  localparam int unsigned ADDR_PEND   = 2;
  localparam int unsigned ADDR_CTRL   = 3;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_BLOCK  = 2'd1,
    SEL_PEND   = 2'd2,
    SEL_CTRL   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req_in,
  output logic [NUM_CH-1:0] status_q
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) status_q[g] <= 1'b0;
      else     status_q[g] <= req_in[g];
    end
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned EN_BIT = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [AGG_DATA_W-1:0] wdata,
  output logic [NUM_CH-1:0]     block_q,
  output logic                  gen_en_q
);
  logic hit_block, hit_ctrl;

  always_comb begin
    hit_block = wr_en && (addr == ADDR_W'(ADDR_BLOCK));
    hit_ctrl  = wr_en && (addr == ADDR_W'(ADDR_CTRL));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      block_q  <= '1;
      gen_en_q <= 1'b0;
    end else begin
      if (hit_block) block_q  <= wdata[NUM_CH-1:0];
      if (hit_ctrl)  gen_en_q <= wdata[EN_BIT];
    end
  end
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned EN_BIT = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NUM_CH-1:0]     status,
  input  logic [NUM_CH-1:0]     block,
  input  logic [NUM_CH-1:0]     pend,
  input  logic                  gen_en,
  output logic [AGG_DATA_W-1:0] rdata_q
);
  localparam int unsigned SEL_W = 2;
  logic                  mapped;
  reg_sel_e              sel;
  logic [AGG_DATA_W-1:0] word;

  always_comb begin
    mapped = (addr >> SEL_W) == '0;
    sel    = reg_sel_e'(addr[SEL_W-1:0]);
    word   = '0;
    if (mapped) begin
      unique case (sel)
        SEL_STATUS: word[NUM_CH-1:0] = status;
        SEL_BLOCK:  word[NUM_CH-1:0] = block;
        SEL_PEND:   word[NUM_CH-1:0] = pend;
        SEL_CTRL:   word[EN_BIT]     = gen_en;
        default:    word             = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= word;
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] status,
  input  logic [NUM_CH-1:0] block,
  input  logic              gen_en,
  output logic [NUM_CH-1:0] pend,
  output logic              irq_q
);
  always_comb pend = status & ~block;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= gen_en && (|pend);
  end
endmodule

// File: rtl/chan_irq_combiner.sv
module chan_irq_combiner
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned EN_BIT = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_CH-1:0]     chan_req,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_wr_en,
  input  logic [AGG_DATA_W-1:0] reg_wdata,
  input  logic                  reg_rd_en,
  output logic [AGG_DATA_W-1:0] reg_rdata,
  output logic                  dev_irq
);
  logic [NUM_CH-1:0] status_q;
  logic [NUM_CH-1:0] block_q;
  logic [NUM_CH-1:0] pend;
  logic              gen_en_q;

  irq_req_capture #(.NUM_CH(NUM_CH)) u_capture (
    .clk(clk), .rst(rst), .req_in(chan_req), .status_q(status_q)
  );

  irq_ctrl_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .EN_BIT(EN_BIT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .block_q(block_q), .gen_en_q(gen_en_q)
  );

  irq_out_stage #(.NUM_CH(NUM_CH)) u_out (
    .clk(clk), .rst(rst), .status(status_q), .block(block_q),
    .gen_en(gen_en_q), .pend(pend), .irq_q(dev_irq)
  );

  irq_read_port #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .EN_BIT(EN_BIT)) u_rd (
    .clk(clk), .rst(rst), .rd_en(reg_rd_en), .addr(reg_addr),
    .status(status_q), .block(block_q), .pend(pend), .gen_en(gen_en_q),
    .rdata_q(reg_rdata)
  );
endmodule

// File: rtl/chan_irq_combiner_chk.sv
module chan_irq_combiner_chk #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned EN_BIT = 20
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] chan_req,
  input logic [NUM_CH-1:0] status_q,
  input logic [NUM_CH-1:0] block_q,
  input logic              gen_en_q,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd_en,
  input logic [31:0]       reg_rdata,
  input logic              dev_irq
);
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  // R6: one clock after a reset cycle every channel is blocked and the enable is off
  always_ff @(posedge clk) begin
    if (rst_seen) begin
      a_r6_reset_state: assert (block_q == '1 && !gen_en_q && !dev_irq)
        else $error("a_r6_reset_state");
    end
  end

  // R1: status follows the request level one clock later
  a_r1_status_follow: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> status_q == $past(chan_req));

  // R5: a set line needs the enable and an open pending channel one clock before
  a_r5_irq_cause: assert property (@(posedge clk) disable iff (rst)
    dev_irq |-> $past(gen_en_q) && ($past(status_q & ~block_q) != '0));

  // R7: a fully blocked vector silences the line on the next clock
  a_r7_all_blocked: assert property (@(posedge clk) disable iff (rst)
    (block_q == '1) |=> !dev_irq);

  // R8: unchanged sources give an unchanged output
  a_r8_no_glitch: assert property (@(posedge clk) disable iff (rst)
    ($stable(block_q) && $stable(gen_en_q) && $stable(status_q)) |=> $stable(dev_irq));

  // R4: a control read returns nothing outside the enable bit
  a_r4_ctrl_bits: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && reg_addr == ADDR_W'(3)) |=> (reg_rdata & ~(32'd1 << EN_BIT)) == 32'd0);

  // R9: unused addresses read zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && reg_addr > ADDR_W'(3)) |=> reg_rdata == 32'd0);
endmodule

bind chan_irq_combiner chan_irq_combiner_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .EN_BIT(EN_BIT)
) u_chk (
  .clk(clk), .rst(rst), .chan_req(chan_req), .status_q(status_q),
  .block_q(block_q), .gen_en_q(gen_en_q), .reg_addr(reg_addr),
  .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata), .dev_irq(dev_irq)
);

// File: tb/chan_irq_combiner_bench.sv
module chan_irq_combiner_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] chan_req = '0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd_en = 1'b0;
  logic [31:0] reg_rdata;
  logic        dev_irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_irq_combiner u_chan_irq_combiner (
    .clk(clk), .rst(rst), .chan_req(chan_req), .reg_addr(reg_addr),
    .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rd_en(reg_rd_en),
    .reg_rdata(reg_rdata), .dev_irq(dev_irq)
  );

  // req, block, enable, expected pending, expected irq
  typedef struct packed {
    logic [15:0] req;
    logic [15:0] blk;
    logic        en;
    logic [15:0] pend;
    logic        irq;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{16'h0001, 16'hFFFF, 1'b1, 16'h0000, 1'b0},
    '{16'h0001, 16'hFFFE, 1'b1, 16'h0001, 1'b1},
    '{16'h0001, 16'hFFFE, 1'b0, 16'h0001, 1'b0},
    '{16'h8000, 16'h7FFF, 1'b1, 16'h8000, 1'b1},
    '{16'hA5A5, 16'h0F0F, 1'b1, 16'hA0A0, 1'b1},
    '{16'hA5A5, 16'h5A5A, 1'b1, 16'hA5A5, 1'b1},
    '{16'h5A5A, 16'h5A5A, 1'b1, 16'h0000, 1'b0},
    '{16'hFFFF, 16'h0000, 1'b1, 16'hFFFF, 1'b1},
    '{16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd_en = 1'b1;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R6 reset values
    check("R6 irq", {31'd0, dev_irq}, 32'd0);
    rd(4'd1, d); check("R6 block", d, 32'h0000FFFF);
    rd(4'd3, d); check("R6 ctrl", d, 32'd0);
    rd(4'd2, d); check("R6 pend", d, 32'd0);

    // table walk: R2 R3 R5
    for (int i = 0; i < NV; i++) begin
      chan_req = VECS[i].req;
      wr(4'd1, {16'd0, VECS[i].blk});
      wr(4'd3, {11'd0, VECS[i].en, 20'd0});
      @(negedge clk); @(negedge clk);
      rd(4'd2, d); check($sformatf("R3 pend vec%0d", i), d, {16'd0, VECS[i].pend});
      check($sformatf("R5 irq vec%0d", i), {31'd0, dev_irq}, {31'd0, VECS[i].irq});
      rd(4'd1, d); check($sformatf("R2 block vec%0d", i), d, {16'd0, VECS[i].blk});
    end

    // R1 status follows input, writes ignored
    chan_req = 16'h3C01;
    @(negedge clk);
    rd(4'd0, d); check("R1 status", d, 32'h00003C01);
    wr(4'd0, 32'hFFFFFFFF);
    rd(4'd0, d); check("R1 status write ignored", d, 32'h00003C01);
    // R3 pend write ignored (block is 0, enable set)
    wr(4'd2, 32'h0);
    rd(4'd2, d); check("R3 pend write ignored", d, 32'h00003C01);

    // R4 control other bits read 0
    wr(4'd3, 32'hFFFFFFFF);
    rd(4'd3, d); check("R4 ctrl readback", d, 32'h00100000);
    // R9 unmapped read zero and read data holds
    rd(4'd5, d); check("R9 unmapped", d, 32'd0);
    rd(4'd3, d); @(negedge clk); check("R9 hold", reg_rdata, 32'h00100000);

    // R5 latency: enable off then on, irq one clock after register
    wr(4'd3, 32'h0);
    @(negedge clk);
    check("R5 irq off", {31'd0, dev_irq}, 32'd0);
    wr(4'd3, 32'h00100000);
    check("R5 irq one clock later still 0", {31'd0, dev_irq}, 32'd0);
    @(negedge clk);
    check("R5 irq set", {31'd0, dev_irq}, 32'd1);

    // R8 rewrite same block value, irq stays high every cycle
    wr(4'd1, 32'h0000C3FE);
    @(negedge clk);
    check("R8 before", {31'd0, dev_irq}, 32'd1);
    for (int k = 0; k < 3; k++) begin
      wr(4'd1, 32'h0000C3FE);
      check($sformatf("R8 rewrite %0d", k), {31'd0, dev_irq}, 32'd1);
    end

    // R7 all ones blocks everything
    chan_req = 16'hFFFF;
    @(negedge clk);
    wr(4'd1, 32'hFFFFFFFF);
    check("R7 latency", {31'd0, dev_irq}, 32'd1);
    @(negedge clk);
    check("R7 all blocked", {31'd0, dev_irq}, 32'd0);
    rd(4'd2, d); check("R7 pend zero", d, 32'd0);

    // R6 reset in mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd(4'd1, d); check("R6 block after rerun reset", d, 32'h0000FFFF);
    rd(4'd3, d); check("R6 ctrl after rerun reset", d, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule